// File: doc/BRIEF.md
# Watchdog and Low-Voltage Reset Supervisor

This block produces the active-low reset line that a host processor sees. Two events can pull the line low. The first is a watchdog period that runs out because the host did not restart it in time. The second is a supply-fault flag from an external comparator, which is high while the supply sits below its trip level. Once the line is pulled low, it stays low for a fixed number of timebase ticks. While the supply fault persists it stays low, and after the fault clears it stays low for one more full hold time.

The timebase is a one-cycle enable derived from a 32.768 kHz oscillator. A two-bit setting selects the watchdog period: one of three lengths (about 1.75 s, 0.75 s or 0.25 s at default parameters), or off. The host restarts the count with a one-cycle kick strobe. The analog comparator, the power switching and the bus decoder that produces the kick strobe are outside the block.

A two-bit cause output records whether the most recent trigger came from the watchdog or from the supply. The host clears it with a strobe. The reset output models an open-drain pin: 0 means the pin is pulled low, 1 means it is released.

Top module: `wdt_lv_supervisor`

## Requirements
- R1: While `rst_n` is low, `host_rst_n` is 0 and `rst_cause` is 00. After `rst_n` rises, `host_rst_n` stays 0 until HOLD_TICKS tick edges have been counted, then goes to 1.
- R2: The watchdog period is set by `wd_sel`: 00 gives 7×BASE_TICKS ticks, 01 gives 3×BASE_TICKS ticks and 10 gives BASE_TICKS ticks. If the count is restarted and no further restart follows, `host_rst_n` goes to 0 after the tick edge that completes the period.
- R3: When `lv_low` is 1 at a clock edge, `host_rst_n` is 0 after that edge.
- R4: With `wd_sel` = 11 the watchdog is off and never pulls `host_rst_n` low.
- R5: Both a `wd_kick` pulse and any change of `wd_sel` restart the watchdog count from zero.
- R6: The watchdog count is held at zero while the reset is asserted and starts again at release. Watchdog resets that are never serviced therefore repeat every period plus HOLD_TICKS ticks.
- R7: After a watchdog trigger, `host_rst_n` is 0 for exactly HOLD_TICKS tick edges. After a supply fault, it stays 0 while `lv_low` is 1 and then for HOLD_TICKS further tick edges.
- R8: Only clock edges with `tick_en` = 1 advance the watchdog count or the hold count.
- R9: `rst_cause` becomes 01 on a watchdog trigger and 10 for each cycle in which `lv_low` is 1. A `cause_clr` pulse returns it to 00, but a trigger in the same cycle wins over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_en | input | 1 | One-cycle enable at the 32.768 kHz rate |
| wd_sel | input | 2 | Period select: 00 long, 01 middle, 10 short, 11 off |
| wd_kick | input | 1 | One-cycle strobe that restarts the watchdog |
| lv_low | input | 1 | Supply below trip level (synchronous to clk) |
| cause_clr | input | 1 | One-cycle strobe that clears the cause code |
| host_rst_n | output | 1 | Reset to the host: 0 pulls low, 1 released |
| rst_cause | output | 2 | Cause of the last trigger: 00 none, 01 watchdog, 10 supply |

## Verification
Suppose the watchdog count is off by one, or is not cleared on a kick, a period change or a reset. The falling edge of `host_rst_n` then moves away from its expected cycle, so a check one cycle before and one cycle after the computed edge exposes it within one watchdog period. A hold counter that is wrong shows up as a release edge at the wrong cycle, at most HOLD_TICKS ticks after the trigger. If the watchdog is not frozen while the reset is asserted, the second unserviced expiry is misplaced. A cause register with the wrong priority shows the wrong code on the cycle right after the trigger or the clear.

// File: rtl/sup_pkg.sv
// Package: shared encodings for the reset supervisor.
// Assumes: the select and cause codes below are fixed by the requirements.
package sup_pkg;

    // Watchdog period select codes
    typedef enum logic [1:0] {
        WDP_LONG  = 2'b00,
        WDP_MID   = 2'b01,
        WDP_SHORT = 2'b10,
        WDP_OFF   = 2'b11
    } wd_period_e;

    // Reset cause codes
    typedef enum logic [1:0] {
        CAUSE_NONE = 2'b00,
        CAUSE_WDOG = 2'b01,
        CAUSE_LOWV = 2'b10
    } rst_cause_e;

    // Period multipliers applied to the base tick count
    localparam int unsigned MULT_LONG  = 7;
    localparam int unsigned MULT_MID   = 3;
    localparam int unsigned MULT_SHORT = 1;

endpackage

// File: rtl/sup_wdog_counter.sv
// Module: watchdog tick counter.
// Counts tick enables toward the period chosen by sel.
// Emits a one-cycle expire pulse on the tick that completes the period.
// Assumes: BASE_TICKS >= 2; kick, sel and hold_active are synchronous to clk.
module sup_wdog_counter
    import sup_pkg::*;
#(
    parameter int unsigned BASE_TICKS = 8192
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_en,
    input  logic [1:0] sel,
    input  logic       kick,
    input  logic       hold_active,
    output logic       expire
);
    localparam int unsigned CNT_W = $clog2(MULT_LONG * BASE_TICKS + 1);
    localparam logic [CNT_W-1:0] LAST_LONG  = CNT_W'(MULT_LONG * BASE_TICKS - 1);
    localparam logic [CNT_W-1:0] LAST_MID   = CNT_W'(MULT_MID * BASE_TICKS - 1);
    localparam logic [CNT_W-1:0] LAST_SHORT = CNT_W'(MULT_SHORT * BASE_TICKS - 1);

    logic [CNT_W-1:0] cnt_q;
    logic [1:0]       sel_q;
    logic [CNT_W-1:0] last_val;
    logic             sel_chg;
    logic             is_off;
    logic             restart;
    logic             at_last;

    // Remember the previous select so that a change can restart the count
    always_ff @(posedge clk) begin
        if (!rst_n) sel_q <= WDP_LONG;
        else        sel_q <= sel;
    end

    // Decode the terminal count for the selected period
    always_comb begin
        last_val = LAST_LONG;
        is_off   = 1'b0;
        case (sel)
            WDP_LONG:  last_val = LAST_LONG;
            WDP_MID:   last_val = LAST_MID;
            WDP_SHORT: last_val = LAST_SHORT;
            default:   is_off   = 1'b1;
        endcase
    end

    assign sel_chg = (sel != sel_q);
    assign restart = hold_active | kick | sel_chg | is_off;
    assign at_last = (cnt_q == last_val);
    assign expire  = tick_en & at_last & ~restart;

    // Advance the count on ticks; clear it on restart or at the end of a period
    always_ff @(posedge clk) begin
        if (!rst_n)                cnt_q <= '0;
        else if (restart)          cnt_q <= '0;
        else if (tick_en) begin
            if (at_last)           cnt_q <= '0;
            else                   cnt_q <= cnt_q + 1'b1;
        end
    end

    AST_CNT_HELD_IN_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        hold_active |=> (cnt_q == '0)); // R6
    AST_KICK_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
        kick |=> (cnt_q == '0)); // R5
    AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST_LONG); // R2

endmodule

// File: rtl/sup_reset_stretch.sv
// Module: reset pulse stretcher.
// Holds the reset active for HOLD_TICKS tick edges after the last trigger.
// A supply fault keeps the hold count cleared for as long as it lasts.
// Assumes: HOLD_TICKS >= 2; lv_low is already synchronous to clk.
module sup_reset_stretch #(
    parameter int unsigned HOLD_TICKS = 8192
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_en,
    input  logic wd_expire,
    input  logic lv_low,
    output logic hold_active
);
    localparam int unsigned HOLD_W = $clog2(HOLD_TICKS);
    localparam logic [HOLD_W-1:0] HOLD_LAST = HOLD_W'(HOLD_TICKS - 1);

    logic [HOLD_W-1:0] hold_q;
    logic              active_q;

    // Start or extend the pulse on a trigger; count it down on ticks otherwise
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b1;
            hold_q   <= '0;
        end else if (lv_low || wd_expire) begin
            active_q <= 1'b1;
            hold_q   <= '0;
        end else if (active_q && tick_en) begin
            if (hold_q == HOLD_LAST) begin
                active_q <= 1'b0;
                hold_q   <= '0;
            end else begin
                hold_q   <= hold_q + 1'b1;
            end
        end
    end

    assign hold_active = active_q;

    AST_RELEASE_AFTER_FULL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(active_q) |-> ($past(hold_q) == HOLD_LAST && !$past(lv_low))); // R7

endmodule

// File: rtl/sup_cause_reg.sv
// Module: reset cause register.
// Records which trigger fired last. A supply fault wins over a watchdog
// trigger, and any trigger wins over a host clear in the same cycle.
// Assumes: clr is a one-cycle strobe synchronous to clk.
module sup_cause_reg
    import sup_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wd_expire,
    input  logic       lv_low,
    input  logic       clr,
    output logic [1:0] cause
);
    rst_cause_e cause_q;

    // Update the cause code by priority: supply, watchdog, clear
    always_ff @(posedge clk) begin
        if (!rst_n)          cause_q <= CAUSE_NONE;
        else if (lv_low)     cause_q <= CAUSE_LOWV;
        else if (wd_expire)  cause_q <= CAUSE_WDOG;
        else if (clr)        cause_q <= CAUSE_NONE;
    end

    assign cause = cause_q;

endmodule

// File: rtl/wdt_lv_supervisor.sv
// Module: watchdog and low-voltage reset supervisor (top).
// Joins the watchdog counter, the pulse stretcher and the cause register.
// Output host_rst_n models an open-drain pin: 0 pulls low, 1 releases it.
// Assumes: tick_en pulses at the 32.768 kHz rate; all inputs are synchronous.
module wdt_lv_supervisor
    import sup_pkg::*;
#(
    parameter int unsigned BASE_TICKS = 8192,
    parameter int unsigned HOLD_TICKS = 8192
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_en,
    input  logic [1:0] wd_sel,
    input  logic       wd_kick,
    input  logic       lv_low,
    input  logic       cause_clr,
    output logic       host_rst_n,
    output logic [1:0] rst_cause
);
    logic wd_expire;
    logic hold_active;

    sup_wdog_counter #(.BASE_TICKS(BASE_TICKS)) u_wdog (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick_en     (tick_en),
        .sel         (wd_sel),
        .kick        (wd_kick),
        .hold_active (hold_active),
        .expire      (wd_expire)
    );

    sup_reset_stretch #(.HOLD_TICKS(HOLD_TICKS)) u_stretch (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick_en     (tick_en),
        .wd_expire   (wd_expire),
        .lv_low      (lv_low),
        .hold_active (hold_active)
    );

    sup_cause_reg u_cause (
        .clk       (clk),
        .rst_n     (rst_n),
        .wd_expire (wd_expire),
        .lv_low    (lv_low),
        .clr       (cause_clr),
        .cause     (rst_cause)
    );

    assign host_rst_n = ~hold_active;

    AST_LV_PULLS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        lv_low |=> !host_rst_n); // R3
    AST_LV_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        lv_low |=> (rst_cause == CAUSE_LOWV)); // R9
    AST_OFF_STAYS_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rst_n && !lv_low && wd_sel == WDP_OFF) |=> host_rst_n); // R4
    AST_WD_FALL_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(host_rst_n) && !$past(lv_low)) |-> (rst_cause == CAUSE_WDOG)); // R9

endmodule

// File: tb/sim_wdt_lv_supervisor.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver pushes (cycle, expected outputs) items and the
// monitor pops and compares each one at the negedge of its cycle.
module sim_wdt_lv_supervisor;
    localparam int BASE = 16;
    localparam int HOLD = 16;
    localparam int L_LONG  = 7 * BASE;
    localparam int L_MID   = 3 * BASE;
    localparam int L_SHORT = BASE;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_en = 1'b1;
    logic [1:0] wd_sel = 2'b01;
    logic       wd_kick = 1'b0;
    logic       lv_low = 1'b0;
    logic       cause_clr = 1'b0;
    logic       host_rst_n;
    logic [1:0] rst_cause;

    typedef struct {
        int         at;
        logic       rst;
        logic [1:0] cause;
        string      tag;
    } exp_t;

    exp_t q[$];
    exp_t cur;
    int   cyc = 0;
    int   n_chk = 0;
    int   n_err = 0;
    bit   done = 1'b0;

    always #2.5 clk = ~clk;

    // Count clock edges so that expected items can name their cycle
    always @(posedge clk) cyc <= cyc + 1;

    wdt_lv_supervisor #(.BASE_TICKS(BASE), .HOLD_TICKS(HOLD)) u0 (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wd_sel(wd_sel),
        .wd_kick(wd_kick), .lv_low(lv_low), .cause_clr(cause_clr),
        .host_rst_n(host_rst_n), .rst_cause(rst_cause)
    );

    // Monitor: compare every item that falls due in this cycle
    always @(negedge clk) begin
        while (q.size() > 0 && q[0].at <= cyc) begin
            cur = q.pop_front();
            n_chk++;
            if (cur.at != cyc || host_rst_n !== cur.rst || rst_cause !== cur.cause) begin
                n_err++;
                $display("FAIL %s: cycle %0d (due %0d) host_rst_n=%b rst_cause=%b, expected %b %b",
                         cur.tag, cyc, cur.at, host_rst_n, rst_cause, cur.rst, cur.cause);
            end
        end
    end

    task automatic push_exp(input int at, input logic r, input logic [1:0] c, input string tag);
        exp_t e;
        e.at = at; e.rst = r; e.cause = c; e.tag = tag;
        q.push_back(e);
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic drain();
        while (q.size() > 0) @(negedge clk);
    endtask

    task automatic kick();
        wd_kick = 1'b1;
        @(negedge clk);
        wd_kick = 1'b0;
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    // Watchdog on the bench itself
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL timeout: run hung at cycle %0d, expected completion", cyc);
            finish_run();
        end
    end

    // Driver
    initial begin
        int c;
        int s;
        step(3);
        // R1: state during reset and the hold that follows power-on
        c = cyc;
        push_exp(c, 1'b0, 2'b00, "R1 in reset");
        push_exp(c + HOLD - 1, 1'b0, 2'b00, "R1 hold before release");
        push_exp(c + HOLD, 1'b1, 2'b00, "R1 released");
        rst_n = 1'b1;
        drain();

        // R2/R7/R6: middle period expiry, exact hold, repeat spacing
        c = cyc;
        push_exp(c + L_MID, 1'b1, 2'b00, "R2 not yet expired");
        push_exp(c + 1 + L_MID, 1'b0, 2'b01, "R2 expiry pulls low");
        push_exp(c + L_MID + HOLD, 1'b0, 2'b01, "R7 held full time");
        push_exp(c + 1 + L_MID + HOLD, 1'b1, 2'b01, "R7 released");
        push_exp(c + 2 * L_MID + HOLD, 1'b1, 2'b01, "R6 count resumed at release");
        push_exp(c + 1 + 2 * L_MID + HOLD, 1'b0, 2'b01, "R6 second expiry");
        kick();
        drain();
        step(HOLD + 2);

        // R5: regular kicks keep the line released
        for (int i = 0; i < 4; i++) begin
            c = cyc;
            push_exp(c + 40, 1'b1, 2'b01, "R5 kick keeps released");
            kick();
            step(39);
        end
        // R9: clear strobe (with a kick in the same cycle)
        c = cyc;
        push_exp(c + 1, 1'b1, 2'b00, "R9 clear returns 00");
        wd_kick = 1'b1;
        cause_clr = 1'b1;
        @(negedge clk);
        wd_kick = 1'b0;
        cause_clr = 1'b0;

        // R5: select change restarts the count
        step(29);
        s = cyc;
        c = s - 30;
        push_exp(c + 1 + L_MID, 1'b1, 2'b00, "R5 old period ignored after select change");
        push_exp(s + L_LONG, 1'b1, 2'b00, "R2 long period not yet expired");
        push_exp(s + 1 + L_LONG, 1'b0, 2'b01, "R2 long period expiry");
        wd_sel = 2'b00;
        drain();
        step(HOLD + 2);

        // R2: short period
        c = cyc;
        push_exp(c + L_SHORT, 1'b1, 2'b01, "R2 short period not yet expired");
        push_exp(c + 1 + L_SHORT, 1'b0, 2'b01, "R2 short period expiry");
        wd_sel = 2'b10;
        drain();
        step(HOLD + 2);

        // R4: watchdog off
        c = cyc;
        push_exp(c + 100, 1'b1, 2'b01, "R4 off stays released");
        push_exp(c + 200, 1'b1, 2'b01, "R4 off still released");
        wd_sel = 2'b11;
        drain();

        // R8: the count stalls while tick_en is low
        c = cyc;
        push_exp(c + 100 + L_MID, 1'b1, 2'b01, "R8 stall delays expiry");
        push_exp(c + 101 + L_MID, 1'b0, 2'b01, "R8 expiry after stall");
        wd_sel = 2'b01;
        @(negedge clk);
        tick_en = 1'b0;
        step(100);
        tick_en = 1'b1;
        drain();
        step(HOLD + 2);

        // R3/R7/R9: supply fault, extension, clear ignored during fault
        wd_sel = 2'b11;
        @(negedge clk);
        c = cyc;
        push_exp(c, 1'b1, 2'b01, "R3 before fault");
        push_exp(c + 1, 1'b0, 2'b10, "R3 fault pulls low");
        push_exp(c + 11, 1'b0, 2'b10, "R9 clear loses to fault");
        push_exp(c + 30, 1'b0, 2'b10, "R7 extended during fault");
        push_exp(c + 40 + HOLD - 1, 1'b0, 2'b10, "R7 held after recovery");
        push_exp(c + 40 + HOLD, 1'b1, 2'b10, "R7 released after recovery");
        lv_low = 1'b1;
        step(10);
        cause_clr = 1'b1;
        @(negedge clk);
        cause_clr = 1'b0;
        step(29);
        lv_low = 1'b0;
        drain();

        finish_run();
    end

endmodule